// File: doc/BRIEF.md
# Mobile SDRAM Command Decoder

This block sits on the device side of a single-data-rate mobile SDRAM pin interface. On each rising clock edge it captures the clock-enable, chip-select, row/column strobes, write-enable, byte mask, bank and address pins. It turns them into one registered command strobe per cycle, together with the bank, row, column and option fields that belong to that command.

Mode-register-set commands load the normal or the extended mode register, chosen by the bank pins. The byte mask pin drives two outputs. One is a write-mask flag on the same cycle. The other is a read output-enable that follows the mask pin two clocks later.

A burst-terminate aimed at a burst issued with auto precharge is reported as illegal rather than issued. The memory array, refresh and bank timing, and the data path are handled elsewhere.

Top module: `msdr_cmd_decode`

## Requirements
- R1: A command sampled at rising edge k appears on its strobe output for exactly the one cycle after edge k, and at most one command strobe is high in any cycle.
- R2: With cs_n_i low, the encodings on (ras_n_i, cas_n_i, we_n_i) are: 0,1,1 activate; 1,0,1 read; 1,0,0 write; 1,1,0 terminate; 0,1,0 precharge; 0,0,1 refresh; 0,0,0 mode set; 1,1,1 no operation. A cycle with cs_n_i high, or a no-operation cycle, raises no strobe and changes no field.
- R3: Activate loads bank_o from ba_i and row_o from all twelve address bits.
- R4: Read and write load bank_o from ba_i, col_o from addr_i[8:0], and auto_pre_o from addr_i[10].
- R5: The terminate encoding raises bst_o when cke_i is high and dpd_o (deep power-down entry) when cke_i is low.
- R6: The refresh encoding raises aref_o when cke_i is high and sref_o (self-refresh entry) when cke_i is low; in both cases bank_o, row_o, col_o, auto_pre_o and pre_all_o are left unchanged.
- R7: Precharge copies addr_i[10] into pre_all_o. With addr_i[10] low, bank_o takes ba_i. With addr_i[10] high, bank_o is left unchanged.
- R8: Mode set with ba_i = 2'b00 loads mode_reg_o from addr_i. With ba_i = 2'b10 (ba_i[1] = 1, ba_i[0] = 0) it loads ext_mode_reg_o. With ba_i = 2'b01 or 2'b11 neither register changes, though mrs_o still pulses.
- R9: rd_oe_o after edge k+1 equals the inverse of dqm_i sampled at edge k, so reads are masked two clocks after the mask is sampled.
- R10: wr_mask_o after edge k equals dqm_i sampled at edge k.
- R11: A terminate with cke_i high, issued while the most recent read or write had addr_i[10] high, raises bst_illegal_o instead of bst_o. Before any read or write, terminate is legal.
- R12: While rst_n is low (synchronous), all strobes, fields, both mode registers, wr_mask_o and rd_oe_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge samples all pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_i | input | 1 | Clock enable pin, selects power-state variant of two encodings |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| dqm_i | input | 1 | Byte mask pin |
| ba_i | input | 2 | Bank address pins |
| addr_i | input | 12 | Address pins |
| act_o | output | 1 | Activate strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| bst_o | output | 1 | Legal burst-terminate strobe |
| dpd_o | output | 1 | Deep power-down entry strobe |
| pre_o | output | 1 | Precharge strobe |
| aref_o | output | 1 | Auto refresh strobe |
| sref_o | output | 1 | Self-refresh entry strobe |
| mrs_o | output | 1 | Mode register set strobe |
| bst_illegal_o | output | 1 | Terminate aimed at an auto-precharge burst |
| bank_o | output | 2 | Bank of the last bank-addressed command |
| row_o | output | 12 | Row of the last activate |
| col_o | output | 9 | Column of the last read or write |
| auto_pre_o | output | 1 | Auto-precharge option of the last read or write |
| pre_all_o | output | 1 | All-bank option of the last precharge |
| mode_reg_o | output | 12 | Stored mode register |
| ext_mode_reg_o | output | 12 | Stored extended mode register |
| wr_mask_o | output | 1 | Write mask for the current data cycle |
| rd_oe_o | output | 1 | Read data output enable |

## Verification
Every cycle, the assertions check several relations. No two strobes may be high together. Activate and column fields must track the pins of the cycle before. Refresh must leave the address fields alone, and all-bank precharge must leave the bank alone. Reserved mode-set banks must change neither register. Deep power-down must follow a low clock enable. Terminate legality must agree with the stored auto-precharge option. The read enable must lag the mask by two edges.

Only the bench scenarios can show that each encoding maps to the right strobe under both clock-enable levels, that the mode registers receive the right values, and that a later read or write with auto precharge off makes a terminate legal again. The same holds for the exact reset state and for mask sequences that switch every cycle.

// File: rtl/msdr_pkg.sv
// Shared command type for the mobile SDRAM command decoder.
// Assumes one command per cycle; CMD_NONE covers deselect and no-operation.
package msdr_pkg;
    localparam int CMD_W   = 4;
    localparam int NUM_CMD = 9;

    typedef enum logic [CMD_W-1:0] {
        CMD_NONE = 4'd0,
        CMD_ACT  = 4'd1,
        CMD_RD   = 4'd2,
        CMD_WR   = 4'd3,
        CMD_BST  = 4'd4,
        CMD_DPD  = 4'd5,
        CMD_PRE  = 4'd6,
        CMD_AREF = 4'd7,
        CMD_SREF = 4'd8,
        CMD_MRS  = 4'd9
    } msdr_cmd_e;
endpackage

// File: rtl/msdr_cmd_table.sv
// Combinational decode of the control pins into one command code.
// Assumes the pins are stable ahead of the sampling edge; CKE only
// changes the meaning of the terminate and refresh encodings.
module msdr_cmd_table
    import msdr_pkg::*;
(
    input  logic      cke_i,
    input  logic      cs_n_i,
    input  logic      ras_n_i,
    input  logic      cas_n_i,
    input  logic      we_n_i,
    output msdr_cmd_e cmd_o
);
    // Map the three strobe pins (and CKE) onto a command code.
    always_comb begin
        cmd_o = CMD_NONE;
        if (!cs_n_i) begin
            unique case ({ras_n_i, cas_n_i, we_n_i})
                3'b011:  cmd_o = CMD_ACT;
                3'b101:  cmd_o = CMD_RD;
                3'b100:  cmd_o = CMD_WR;
                3'b110:  cmd_o = cke_i ? CMD_BST : CMD_DPD;
                3'b010:  cmd_o = CMD_PRE;
                3'b001:  cmd_o = cke_i ? CMD_AREF : CMD_SREF;
                3'b000:  cmd_o = CMD_MRS;
                default: cmd_o = CMD_NONE;
            endcase
        end
    end
endmodule

// File: rtl/msdr_field_regs.sv
// Holds the address fields that belong to the last command of each kind.
// Assumes the command code is valid in the cycle it is presented; fields
// not touched by a command keep their value.
module msdr_field_regs
    import msdr_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 9,
    parameter int BANK_W = 2,
    parameter int AP_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  msdr_cmd_e         cmd_i,
    input  logic [BANK_W-1:0] ba_i,
    input  logic [ROW_W-1:0]  addr_i,
    output logic [BANK_W-1:0] bank_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  col_o,
    output logic              auto_pre_o,
    output logic              pre_all_o
);
    logic opt_bit;
    assign opt_bit = addr_i[AP_BIT];

    // Bank field: loaded by activate, read, write and single-bank precharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_o <= '0;
        end else if (cmd_i == CMD_ACT || cmd_i == CMD_RD || cmd_i == CMD_WR) begin
            bank_o <= ba_i;
        end else if (cmd_i == CMD_PRE && !opt_bit) begin
            bank_o <= ba_i;
        end
    end

    // Row field: loaded by activate only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_o <= '0;
        end else if (cmd_i == CMD_ACT) begin
            row_o <= addr_i;
        end
    end

    // Column and auto-precharge option: loaded by read and write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_o      <= '0;
            auto_pre_o <= 1'b0;
        end else if (cmd_i == CMD_RD || cmd_i == CMD_WR) begin
            col_o      <= addr_i[COL_W-1:0];
            auto_pre_o <= opt_bit;
        end
    end

    // All-bank option: loaded by precharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_all_o <= 1'b0;
        end else if (cmd_i == CMD_PRE) begin
            pre_all_o <= opt_bit;
        end
    end
endmodule

// File: rtl/msdr_mode_store.sv
// Stores the normal and extended mode registers.
// Assumes bank code 0 selects the normal register and the code with only
// the top bank bit set selects the extended one; all others are reserved.
module msdr_mode_store #(
    parameter int ROW_W  = 12,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrs_i,
    input  logic [BANK_W-1:0] ba_i,
    input  logic [ROW_W-1:0]  addr_i,
    output logic [ROW_W-1:0]  mode_o,
    output logic [ROW_W-1:0]  ext_mode_o
);
    localparam logic [BANK_W-1:0] SEL_NORM = '0;
    localparam logic [BANK_W-1:0] SEL_EXT  = BANK_W'(1) << (BANK_W - 1);

    // Normal mode register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= '0;
        end else if (mrs_i && ba_i == SEL_NORM) begin
            mode_o <= addr_i;
        end
    end

    // Extended mode register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_mode_o <= '0;
        end else if (mrs_i && ba_i == SEL_EXT) begin
            ext_mode_o <= addr_i;
        end
    end
endmodule

// File: rtl/msdr_mask_pipe.sv
// Byte-mask timing: same-cycle write mask and delayed read output enable.
// Assumes LAT >= 1; a masked read disables the outputs LAT edges later.
module msdr_mask_pipe #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dqm_i,
    output logic wr_mask_o,
    output logic rd_oe_o
);
    logic [LAT-1:0] oe_pipe;

    // Write mask follows the mask pin with the command register timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_mask_o <= 1'b0;
        end else begin
            wr_mask_o <= dqm_i;
        end
    end

    // First stage of the read enable delay line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_pipe[0] <= 1'b0;
        end else begin
            oe_pipe[0] <= !dqm_i;
        end
    end

    for (genvar s = 1; s < LAT; s++) begin : g_stage
        // Remaining stages of the read enable delay line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                oe_pipe[s] <= 1'b0;
            end else begin
                oe_pipe[s] <= oe_pipe[s-1];
            end
        end
    end

    assign rd_oe_o = oe_pipe[LAT-1];
endmodule

// File: rtl/msdr_burst_guard.sv
// Remembers the auto-precharge option of the last read or write and flags
// a terminate aimed at such a burst. Assumes no knowledge of burst length.
module msdr_burst_guard
    import msdr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  msdr_cmd_e cmd_i,
    input  logic      opt_i,
    output logic      illegal_o
);
    logic ap_last;

    // Track the option bit of the most recent column command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ap_last <= 1'b0;
        end else if (cmd_i == CMD_RD || cmd_i == CMD_WR) begin
            ap_last <= opt_i;
        end
    end

    assign illegal_o = (cmd_i == CMD_BST) && ap_last;
endmodule

// File: rtl/msdr_cmd_decode.sv
// Top of the mobile SDRAM command decoder. Samples the pins on each rising
// edge and issues one registered command strobe plus its fields.
// Assumes a single clock domain and a synchronous active-low reset.
module msdr_cmd_decode
    import msdr_pkg::*;
#(
    parameter int ROW_W    = 12,
    parameter int COL_W    = 9,
    parameter int BANK_W   = 2,
    parameter int AP_BIT   = 10,
    parameter int MASK_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_i,
    input  logic              cs_n_i,
    input  logic              ras_n_i,
    input  logic              cas_n_i,
    input  logic              we_n_i,
    input  logic              dqm_i,
    input  logic [BANK_W-1:0] ba_i,
    input  logic [ROW_W-1:0]  addr_i,
    output logic              act_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic              bst_o,
    output logic              dpd_o,
    output logic              pre_o,
    output logic              aref_o,
    output logic              sref_o,
    output logic              mrs_o,
    output logic              bst_illegal_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  col_o,
    output logic              auto_pre_o,
    output logic              pre_all_o,
    output logic [ROW_W-1:0]  mode_reg_o,
    output logic [ROW_W-1:0]  ext_mode_reg_o,
    output logic              wr_mask_o,
    output logic              rd_oe_o
);
    msdr_cmd_e          cmd;
    logic               illegal;
    logic [NUM_CMD-1:0] strb_d;
    logic [NUM_CMD-1:0] strb_q;
    logic               ill_q;

    msdr_cmd_table u_table (
        .cke_i   (cke_i),
        .cs_n_i  (cs_n_i),
        .ras_n_i (ras_n_i),
        .cas_n_i (cas_n_i),
        .we_n_i  (we_n_i),
        .cmd_o   (cmd)
    );

    msdr_burst_guard u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (cmd),
        .opt_i     (addr_i[AP_BIT]),
        .illegal_o (illegal)
    );

    // One strobe bit per command code; an illegal terminate is withheld.
    for (genvar c = 0; c < NUM_CMD; c++) begin : g_strb
        if (c + 1 == int'(CMD_BST)) begin : g_bst
            assign strb_d[c] = (cmd == CMD_BST) && !illegal;
        end else begin : g_other
            assign strb_d[c] = (cmd == msdr_cmd_e'(CMD_W'(c + 1)));
        end
    end

    // Register the strobes so each command is a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strb_q <= '0;
            ill_q  <= 1'b0;
        end else begin
            strb_q <= strb_d;
            ill_q  <= illegal;
        end
    end

    assign act_o         = strb_q[int'(CMD_ACT)  - 1];
    assign rd_o          = strb_q[int'(CMD_RD)   - 1];
    assign wr_o          = strb_q[int'(CMD_WR)   - 1];
    assign bst_o         = strb_q[int'(CMD_BST)  - 1];
    assign dpd_o         = strb_q[int'(CMD_DPD)  - 1];
    assign pre_o         = strb_q[int'(CMD_PRE)  - 1];
    assign aref_o        = strb_q[int'(CMD_AREF) - 1];
    assign sref_o        = strb_q[int'(CMD_SREF) - 1];
    assign mrs_o         = strb_q[int'(CMD_MRS)  - 1];
    assign bst_illegal_o = ill_q;

    msdr_field_regs #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .BANK_W (BANK_W),
        .AP_BIT (AP_BIT)
    ) u_fields (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd),
        .ba_i       (ba_i),
        .addr_i     (addr_i),
        .bank_o     (bank_o),
        .row_o      (row_o),
        .col_o      (col_o),
        .auto_pre_o (auto_pre_o),
        .pre_all_o  (pre_all_o)
    );

    msdr_mode_store #(
        .ROW_W  (ROW_W),
        .BANK_W (BANK_W)
    ) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mrs_i      (cmd == CMD_MRS),
        .ba_i       (ba_i),
        .addr_i     (addr_i),
        .mode_o     (mode_reg_o),
        .ext_mode_o (ext_mode_reg_o)
    );

    msdr_mask_pipe #(
        .LAT (MASK_LAT)
    ) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .dqm_i     (dqm_i),
        .wr_mask_o (wr_mask_o),
        .rd_oe_o   (rd_oe_o)
    );
endmodule

// File: rtl/msdr_cmd_decode_chk.sv
// Property checker for the command decoder, attached through bind.
// Assumes the default pin widths' meaning of the option bit position.
module msdr_cmd_decode_chk #(
    parameter int ROW_W    = 12,
    parameter int COL_W    = 9,
    parameter int BANK_W   = 2,
    parameter int AP_BIT   = 10,
    parameter int MASK_LAT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke_i,
    input logic              dqm_i,
    input logic [BANK_W-1:0] ba_i,
    input logic [ROW_W-1:0]  addr_i,
    input logic              act_o,
    input logic              rd_o,
    input logic              wr_o,
    input logic              bst_o,
    input logic              dpd_o,
    input logic              pre_o,
    input logic              aref_o,
    input logic              sref_o,
    input logic              mrs_o,
    input logic              bst_illegal_o,
    input logic [BANK_W-1:0] bank_o,
    input logic [ROW_W-1:0]  row_o,
    input logic [COL_W-1:0]  col_o,
    input logic              auto_pre_o,
    input logic              pre_all_o,
    input logic [ROW_W-1:0]  mode_reg_o,
    input logic [ROW_W-1:0]  ext_mode_reg_o,
    input logic              rd_oe_o
);
    localparam logic [BANK_W-1:0] SEL_NORM = '0;
    localparam logic [BANK_W-1:0] SEL_EXT  = BANK_W'(1) << (BANK_W - 1);

    logic [1:0] since_rst;

    // Count edges since reset, saturating, to gate history-based checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_o, rd_o, wr_o, bst_o, dpd_o, pre_o, aref_o, sref_o, mrs_o, bst_illegal_o})); // R1

    AST_ACT_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        act_o |-> (row_o == $past(addr_i) && bank_o == $past(ba_i))); // R3

    AST_COL_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_o || wr_o) |-> (col_o == $past(addr_i[COL_W-1:0]) && auto_pre_o == $past(addr_i[AP_BIT]))); // R4

    AST_DPD_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        dpd_o |-> !$past(cke_i)); // R5

    AST_REFRESH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (aref_o || sref_o) |-> ($stable(bank_o) && $stable(row_o) && $stable(col_o) && $stable(auto_pre_o))); // R6

    AST_PREALL_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_o && pre_all_o) |-> $stable(bank_o)); // R7

    AST_MRS_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_o && $past(ba_i) != SEL_NORM && $past(ba_i) != SEL_EXT)
            |-> ($stable(mode_reg_o) && $stable(ext_mode_reg_o))); // R8

    AST_BST_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        bst_illegal_o |-> auto_pre_o); // R11

    AST_BST_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        bst_o |-> !auto_pre_o); // R11

    if (MASK_LAT == 2) begin : g_lat2
        AST_RDOE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= 2'd2) |-> (rd_oe_o == !$past(dqm_i, 2))); // R9
    end
endmodule

bind msdr_cmd_decode msdr_cmd_decode_chk #(
    .ROW_W    (ROW_W),
    .COL_W    (COL_W),
    .BANK_W   (BANK_W),
    .AP_BIT   (AP_BIT),
    .MASK_LAT (MASK_LAT)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cke_i          (cke_i),
    .dqm_i          (dqm_i),
    .ba_i           (ba_i),
    .addr_i         (addr_i),
    .act_o          (act_o),
    .rd_o           (rd_o),
    .wr_o           (wr_o),
    .bst_o          (bst_o),
    .dpd_o          (dpd_o),
    .pre_o          (pre_o),
    .aref_o         (aref_o),
    .sref_o         (sref_o),
    .mrs_o          (mrs_o),
    .bst_illegal_o  (bst_illegal_o),
    .bank_o         (bank_o),
    .row_o          (row_o),
    .col_o          (col_o),
    .auto_pre_o     (auto_pre_o),
    .pre_all_o      (pre_all_o),
    .mode_reg_o     (mode_reg_o),
    .ext_mode_reg_o (ext_mode_reg_o),
    .rd_oe_o        (rd_oe_o)
);

// File: tb/sim_msdr_cmd_decode.sv
`timescale 1ns/1ps
module sim_msdr_cmd_decode;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dqm = 1'b1;
    logic [1:0]  ba = '0;
    logic [11:0] addr = '0;
    logic        act, rd, wr, bst, dpd, pre, aref, sref, mrs, ill;
    logic [1:0]  bank;
    logic [11:0] row;
    logic [8:0]  col;
    logic        ap, pall, wmask, rdoe;
    logic [11:0] mode, ext;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    msdr_cmd_decode u0 (
        .clk(clk), .rst_n(rst_n), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
        .cas_n_i(cas_n), .we_n_i(we_n), .dqm_i(dqm), .ba_i(ba), .addr_i(addr),
        .act_o(act), .rd_o(rd), .wr_o(wr), .bst_o(bst), .dpd_o(dpd), .pre_o(pre),
        .aref_o(aref), .sref_o(sref), .mrs_o(mrs), .bst_illegal_o(ill),
        .bank_o(bank), .row_o(row), .col_o(col), .auto_pre_o(ap), .pre_all_o(pall),
        .mode_reg_o(mode), .ext_mode_reg_o(ext), .wr_mask_o(wmask), .rd_oe_o(rdoe)
    );

    typedef struct packed {
        logic [9:0]  strb;   // act rd wr bst dpd pre aref sref mrs ill
        logic [1:0]  bank;
        logic [11:0] row;
        logic [8:0]  col;
        logic        ap;
        logic        pall;
        logic [11:0] mode;
        logic [11:0] ext;
        logic        wm;
        logic        oe;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    // Reference model state, derived from the requirements.
    logic [1:0]  m_bank = '0;
    logic [11:0] m_row = '0, m_mode = '0, m_ext = '0;
    logic [8:0]  m_col = '0;
    logic        m_ap = 0, m_pall = 0, m_stage = 0, m_aplast = 0;

    function automatic exp_t observed();
        exp_t o;
        o.strb = {act, rd, wr, bst, dpd, pre, aref, sref, mrs, ill};
        o.bank = bank; o.row = row; o.col = col; o.ap = ap; o.pall = pall;
        o.mode = mode; o.ext = ext; o.wm = wmask; o.oe = rdoe;
        return o;
    endfunction

    // Driver: apply pins at the falling edge and push the expected result.
    task automatic drive(input string tag, input logic k, input logic c, input logic r,
                         input logic ca, input logic w, input logic [1:0] b,
                         input logic [11:0] a, input logic m);
        exp_t e;
        @(negedge clk);
        cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a; dqm = m;
        e = '0;
        if (!c) begin
            case ({r, ca, w})
                3'b011: begin e.strb[9] = 1; m_bank = b; m_row = a; end
                3'b101, 3'b100: begin
                    if (!ca && w) e.strb[8] = 1; else e.strb[7] = 1;
                    m_bank = b; m_col = a[8:0]; m_ap = a[10]; m_aplast = a[10];
                end
                3'b110: begin
                    if (!k) e.strb[5] = 1;
                    else if (m_aplast) e.strb[0] = 1;
                    else e.strb[6] = 1;
                end
                3'b010: begin e.strb[4] = 1; m_pall = a[10]; if (!a[10]) m_bank = b; end
                3'b001: begin if (k) e.strb[3] = 1; else e.strb[2] = 1; end
                3'b000: begin
                    e.strb[1] = 1;
                    if (b == 2'b00) m_mode = a;
                    else if (b == 2'b10) m_ext = a;
                end
                default: ;
            endcase
        end
        e.bank = m_bank; e.row = m_row; e.col = m_col; e.ap = m_ap; e.pall = m_pall;
        e.mode = m_mode; e.ext = m_ext; e.wm = m;
        e.oe = m_stage; m_stage = !m;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic nop(input string tag, input logic m);
        drive(tag, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 12'h000, m);
    endtask

    // Monitor: after each rising edge, compare against the next expected item.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e, o;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            o = observed();
            n_checks++;
            if (o !== e) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", t, o, e);
            end
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        exp_t z;
        repeat (4) @(negedge clk);
        // R12: reset state while rst_n held low
        z = '0;
        n_checks++;
        if (observed() !== z) begin
            n_fail++;
            $display("FAIL R12: got %h expected %h", observed(), z);
        end
        rst_n = 1'b1;

        drive("R2 deselect", 1, 1, 0, 0, 0, 2'b11, 12'hFFF, 1);
        nop("R2 nop", 1);
        drive("R3 activate", 1, 0, 0, 1, 1, 2'b01, 12'hA5C, 0);
        drive("R1 pulse ends", 1, 0, 1, 1, 1, 2'b10, 12'h123, 0);
        drive("R4 read no-ap", 1, 0, 1, 0, 1, 2'b10, 12'h1F3, 0);
        drive("R5 bst legal", 1, 0, 1, 1, 0, 2'b00, 12'h000, 0);
        drive("R4 write ap", 1, 0, 1, 0, 0, 2'b11, 12'h5AB, 1);
        drive("R11 bst illegal", 1, 0, 1, 1, 0, 2'b00, 12'h000, 1);
        drive("R5 dpd", 0, 0, 1, 1, 0, 2'b01, 12'hFFF, 0);
        drive("R6 aref", 1, 0, 0, 0, 1, 2'b00, 12'h3C3, 1);
        drive("R6 sref", 0, 0, 0, 0, 1, 2'b01, 12'hC3C, 0);
        drive("R7 pre single", 1, 0, 0, 1, 0, 2'b10, 12'h000, 0);
        drive("R7 pre all", 1, 0, 0, 1, 0, 2'b01, 12'h400, 1);
        drive("R8 mrs normal", 1, 0, 0, 0, 0, 2'b00, 12'h032, 0);
        drive("R8 mrs ext", 1, 0, 0, 0, 0, 2'b10, 12'h9E1, 0);
        drive("R8 mrs reserved 01", 1, 0, 0, 0, 0, 2'b01, 12'h777, 1);
        drive("R8 mrs reserved 11", 1, 0, 0, 0, 0, 2'b11, 12'h888, 1);
        drive("R4 read no-ap clears", 1, 0, 1, 0, 1, 2'b00, 12'h0FF, 0);
        drive("R11 bst legal again", 1, 0, 1, 1, 0, 2'b00, 12'h000, 0);
        // R9 / R10: toggling and held mask patterns
        nop("R9 mask 1", 1);
        nop("R9 mask 0", 0);
        nop("R10 mask 1", 1);
        nop("R9 mask 1b", 1);
        nop("R10 mask 0", 0);
        nop("R9 mask 0b", 0);
        nop("R9 mask 1c", 1);
        nop("R9 tail", 0);
        nop("R9 tail2", 0);

        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule